// File: doc/BRIEF.md
# Single-Line Configurable NMI Request Controller

This block watches one external non-maskable interrupt line and turns it into one registered interrupt request for a processor's interrupt controller. The line is first brought into the local clock domain by a two-flop synchronizer. A two-bit trigger code then selects one of four detection schemes: low level, high level, falling edge or rising edge. Each detected event sets a sticky pending flag. An enable flag decides whether the pending flag reaches the request output.

Software reaches the block through a simple 32-bit register port. A write strobe carries an address and write data. The read data is a side-effect-free combinational view of the addressed register. There are three registers: trigger select, pending status and request enable. The pending flag is acknowledged by writing 1 to its bit 0. A layout parameter picks one of three address maps, so the same block drops into different register windows.

Top module: `nmi_line_ctrl`

## Requirements
- R1: While reset is asserted, and at its release, the trigger code is 0, the enable flag is 0, the pending flag is 0 and the request output `irq_req` is 0.
- R2: `nmi_in` passes through exactly two synchronizing flops before detection. A transition applied before clock edge k can set pending no earlier than edge k+2.
- R3: The trigger code is bits [1:0] of the trigger register: 0 = input low level, 1 = falling edge, 2 = input high level, 3 = rising edge. It reads back in bits [1:0].
- R4: In the edge codes (1, 3), one matching transition between consecutive synchronized samples sets the pending flag. The flag stays set until acknowledged.
- R5: In the level codes (0, 2), the pending flag is set again on every clock while the synchronized input is at the active level. An acknowledge therefore only clears it once the input is inactive.
- R6: A write of 1 to bit 0 of the pending register clears the pending flag on that clock edge. A write with bit 0 = 0 leaves it unchanged. The flag reads in bit 0.
- R7: If an event is detected in the same clock as an acknowledge write, the pending flag stays set.
- R8: Bit 0 of the enable register holds the enable flag. `irq_req` equals pending AND enable as they were one clock earlier. With the enable flag at 0, the pending flag still reads back.
- R9: All register bits other than those named above read 0, as does any address that maps no register. Written values of unused bits are dropped.
- R10: `LAYOUT` selects the byte offsets (trigger, pending, enable): 0 → (0x00, 0x04, 0x08), 1 → (0x00, 0x04, 0x34), 2 → (0x0C, 0x10, 0x40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Asynchronous external interrupt line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things:
- the two-clock synchronizer delay;
- that pending holds unless acknowledged, and that an event always sets it, even against an acknowledge;
- the one-cycle gating of the request by the enable flag;
- that the unused read bits stay zero.

Other behaviour only the bench's scenarios can show:
- the meaning of each trigger code across sequences of input transitions;
- the level modes defeating an acknowledge while the line is held active;
- the exact collision timing of an acknowledge against a fresh edge;
- the address maps of the other layouts.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LO_LEVEL = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_HI_LEVEL = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_e;

  // Bit 0 of the code marks edge detection; bit 1 marks the active-high sense.
  function automatic logic trig_is_edge(trig_e m);
    return m[0];
  endfunction

  function automatic logic trig_active_hi(trig_e m);
    return m[1];
  endfunction

  function automatic logic trig_hit(trig_e m, logic cur, logic prev);
    logic hit;
    if (trig_is_edge(m)) begin
      if (trig_active_hi(m)) hit = cur & ~prev;
      else                   hit = ~cur & prev;
    end else begin
      hit = (cur == trig_active_hi(m));
    end
    return hit;
  endfunction

  // Address maps selected by the layout number.
  function automatic int unsigned map_trig_ofs(int unsigned layout);
    return (layout == 2) ? 32'h0C : 32'h00;
  endfunction

  function automatic int unsigned map_pend_ofs(int unsigned layout);
    return (layout == 2) ? 32'h10 : 32'h04;
  endfunction

  function automatic int unsigned map_en_ofs(int unsigned layout);
    int unsigned ofs;
    case (layout)
      1:       ofs = 32'h34;
      2:       ofs = 32'h40;
      default: ofs = 32'h08;
    endcase
    return ofs;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_cur,
  output logic q_prev
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  logic prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign q_cur  = chain_q[STAGES-1];
  assign q_prev = prev_q;

endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_line_pkg::*;
(
  input  trig_e mode,
  input  logic  cur,
  input  logic  prev,
  output logic  hit
);

  assign hit = trig_hit(mode, cur, prev);

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  output trig_e             mode,
  output logic              en,
  output logic              pend,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(map_trig_ofs(LAYOUT));
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(map_pend_ofs(LAYOUT));
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(map_en_ofs(LAYOUT));

  logic sel_trig, sel_pend, sel_en;
  assign sel_trig = (addr == TRIG_A);
  assign sel_pend = (addr == PEND_A);
  assign sel_en   = (addr == EN_A);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:2];

  trig_e mode_q;
  logic  en_q, pend_q, irq_q;

  assign ack = wr & sel_pend & wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= TRIG_LO_LEVEL;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr && sel_trig) mode_q <= trig_e'(wdata[1:0]);
      if (wr && sel_en)   en_q   <= wdata[0];
      pend_q <= evt | (pend_q & ~ack);
      irq_q  <= pend_q & en_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_trig)      rdata[1:0] = mode_q;
    else if (sel_pend) rdata[0]   = pend_q;
    else if (sel_en)   rdata[0]   = en_q;
  end

  assign mode = mode_q;
  assign en   = en_q;
  assign pend = pend_q;
  assign irq  = irq_q;

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LAYOUT      = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req
);

  logic  sync_cur, sync_prev, evt_hit, ack_hit, pend_q, en_q;
  trig_e mode_q;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(nmi_in),
    .q_cur  (sync_cur),
    .q_prev (sync_prev)
  );

  nmi_detect u_det (
    .mode(mode_q),
    .cur (sync_cur),
    .prev(sync_prev),
    .hit (evt_hit)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (reg_wr),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .evt  (evt_hit),
    .mode (mode_q),
    .en   (en_q),
    .pend (pend_q),
    .ack  (ack_hit),
    .rdata(reg_rdata),
    .irq  (irq_req)
  );

endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_in,
  input logic              sync_cur,
  input logic              evt_hit,
  input logic              ack_hit,
  input logic              pend_q,
  input logic              en_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_req
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!pend_q && !en_q && !irq_req));

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n)) |-> (sync_cur == $past(nmi_in, 2)));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_hit) |=> pend_q);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !evt_hit) |=> !pend_q);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> pend_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == $past(pend_q && en_q));

  // R9
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:2] == '0);

endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nmi_in   (nmi_in),
  .sync_cur (sync_cur),
  .evt_hit  (evt_hit),
  .ack_hit  (ack_hit),
  .pend_q   (pend_q),
  .en_q     (en_q),
  .reg_rdata(reg_rdata),
  .irq_req  (irq_req)
);

// File: tb/nmi_line_ctrl_tb_top.sv
module nmi_line_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_TRIG = 8'h00;
  localparam logic [AW-1:0] A_PEND = 8'h04;
  localparam logic [AW-1:0] A_EN   = 8'h08;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nmi_in = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_req;

  logic          b_wr = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] b_rdata;
  logic          b_irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  nmi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(2)) dut_l2 (
    .clk(clk), .rst_n(rst_n), .nmi_in(1'b0), .reg_wr(b_wr),
    .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(b_rdata),
    .irq_req(b_irq)
  );

  // Behavioural reference model
  int m_sync[$] = '{0, 0};
  int m_prev = 0;
  int m_mode = 0;
  int m_en = 0;
  int m_pend = 0;
  int m_irq = 0;

  function automatic int model_event(int mode, int cur, int prev);
    case (mode)
      0: return (cur == 0) ? 1 : 0;
      1: return (prev == 1 && cur == 0) ? 1 : 0;
      2: return (cur == 1) ? 1 : 0;
      default: return (prev == 0 && cur == 1) ? 1 : 0;
    endcase
  endfunction

  function automatic int model_read(logic [AW-1:0] a);
    if (a == A_TRIG) return m_mode;
    if (a == A_PEND) return m_pend;
    if (a == A_EN)   return m_en;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = '{0, 0};
      m_prev = 0; m_mode = 0; m_en = 0; m_pend = 0; m_irq = 0;
    end else begin
      int cur, evt, ack, nxt_pend, nxt_irq;
      cur = m_sync[1];
      evt = model_event(m_mode, cur, m_prev);
      ack = (reg_wr && reg_addr == A_PEND && reg_wdata[0]) ? 1 : 0;
      nxt_pend = (evt != 0 || (m_pend != 0 && ack == 0)) ? 1 : 0;
      nxt_irq = (m_pend != 0 && m_en != 0) ? 1 : 0;
      if (reg_wr && reg_addr == A_TRIG) m_mode = int'(reg_wdata[1:0]);
      if (reg_wr && reg_addr == A_EN)   m_en = int'(reg_wdata[0]);
      m_pend = nxt_pend;
      m_irq = nxt_irq;
      m_prev = cur;
      m_sync.push_front(int'(nmi_in));
      void'(m_sync.pop_back());
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(logic [AW-1:0] a);
    if (!rst_n) return "R1";
    if (a == A_TRIG) return "R3";
    if (a == A_PEND) return "R6";
    if (a == A_EN)   return "R8";
    return "R9";
  endfunction

  // Per-cycle comparison, a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!finished) begin
      check(rst_n ? "R8 irq_req" : "R1 irq_req", {31'b0, irq_req}, DW'(m_irq));
      check(tag_for(reg_addr), reg_rdata, DW'(model_read(reg_addr)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [AW-1:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
  endtask

  task automatic set_in(logic v);
    @(negedge clk);
    nmi_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state, checked by the per-cycle compare while in reset
    reg_addr = A_PEND;
    cyc(4);
    check("R1 pend at reset", reg_rdata, 32'h0);
    rst_n = 1'b1;

    // R5: low-level mode with the line low sets pending at once
    peek(A_PEND);
    cyc(3);
    check("R5 low level pending", reg_rdata, 32'h1);
    wr(A_PEND, 32'h1);
    peek(A_PEND);
    check("R5 ack defeated while active", reg_rdata, 32'h1);

    // R8: enable and request
    wr(A_EN, 32'h1);
    cyc(2);
    check("R8 irq with enable", {31'b0, irq_req}, 32'h1);

    // Line goes high, then acknowledge clears (R5 and R6)
    set_in(1'b1);
    cyc(4);
    wr(A_PEND, 32'h1);
    peek(A_PEND);
    check("R6 ack clears", reg_rdata, 32'h0);

    // R4: rising edge mode, sticky pending
    wr(A_TRIG, 32'h3);
    set_in(1'b0);
    cyc(4);
    peek(A_PEND);
    check("R4 no event on falling in rise mode", reg_rdata, 32'h0);
    set_in(1'b1);
    cyc(4);
    set_in(1'b0);
    cyc(6);
    peek(A_PEND);
    check("R4 rise pending sticky", reg_rdata, 32'h1);
    // R6: write 0 has no effect
    wr(A_PEND, 32'h0);
    peek(A_PEND);
    check("R6 write zero ignored", reg_rdata, 32'h1);
    wr(A_PEND, 32'h1);
    peek(A_PEND);
    check("R6 ack clears edge", reg_rdata, 32'h0);

    // R2: synchronizer latency; rise applied, pending after 3 edges
    set_in(1'b1);
    @(negedge clk);
    reg_addr = A_PEND; #1;
    check("R2 not yet after 1 edge", reg_rdata, 32'h0);
    @(negedge clk); #1;
    check("R2 not yet after 2 edges", reg_rdata, 32'h0);
    @(negedge clk); #1;
    check("R2 set after 3 edges", reg_rdata, 32'h1);
    wr(A_PEND, 32'h1);
    set_in(1'b0);
    cyc(4);

    // R7: acknowledge colliding with a fresh edge
    set_in(1'b1);
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_PEND; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0; #1;
    check("R7 event wins over ack", reg_rdata, 32'h1);
    wr(A_PEND, 32'h1);

    // R3: falling edge code
    wr(A_TRIG, 32'h1);
    peek(A_TRIG);
    check("R3 trig readback", reg_rdata, 32'h1);
    set_in(1'b0);
    cyc(5);
    peek(A_PEND);
    check("R3 falling edge caught", reg_rdata, 32'h1);
    wr(A_PEND, 32'h1);

    // R3 and R5: high level code
    wr(A_TRIG, 32'h2);
    cyc(3);
    peek(A_PEND);
    check("R3 high level idle", reg_rdata, 32'h0);
    set_in(1'b1);
    cyc(4);
    peek(A_PEND);
    check("R5 high level pending", reg_rdata, 32'h1);

    // R8: masking keeps pending visible
    wr(A_EN, 32'h0);
    cyc(2);
    check("R8 irq masked", {31'b0, irq_req}, 32'h0);
    peek(A_PEND);
    check("R8 pending visible while masked", reg_rdata, 32'h1);
    set_in(1'b0);

    // R9: unused bits dropped and unmapped address
    wr(A_TRIG, 32'hFFFF_FFFF);
    peek(A_TRIG);
    check("R9 unused trig bits", reg_rdata, 32'h3);
    wr(A_EN, 32'hFFFF_FFFE);
    peek(A_EN);
    check("R9 enable bit only", reg_rdata, 32'h0);
    peek(8'h20);
    check("R9 unmapped read", reg_rdata, 32'h0);
    cyc(4);

    // R10: alternate layout 2
    @(negedge clk);
    b_wr = 1'b1; b_addr = 8'h40; b_wdata = 32'h1;
    @(negedge clk);
    b_wr = 1'b0; b_addr = 8'h40; #1;
    check("R10 layout2 enable at 0x40", b_rdata, 32'h1);
    b_addr = 8'h08; #1;
    check("R10 layout2 0x08 unmapped", b_rdata, 32'h0);
    b_addr = 8'h10; #1;
    check("R10 layout2 pending at 0x10", b_rdata, 32'h1);
    @(negedge clk);
    b_wr = 1'b1; b_addr = 8'h0C; b_wdata = 32'h2;
    @(negedge clk);
    b_wr = 1'b0; #1;
    check("R10 layout2 trig at 0x0C", b_rdata, 32'h2);
    cyc(2);
    check("R10 layout2 irq", {31'b0, b_irq}, 32'h1);

    cyc(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule